// File: doc/BRIEF.md
# Combinational Hyperbolic Tangent Ladder

This block approximates tanh(x) as a staircase for a neural-network activation stage. The input is a signed-magnitude fixed-point code. The magnitude is reduced to a 4-bit segment index on a grid of 1/8 over [0, 2). Two-level AND/OR logic decodes that index into a 7-bit unsigned level. There is no lookup memory: each output bit is an OR over a shared set of decoded product terms.

Only the positive half is decoded. Because tanh is odd, the input sign is carried straight to the output sign. Magnitudes of 2.0 or more give exactly 1.0. A zero result is always returned as positive zero.

The arithmetic path is purely combinational. The parameter `REG_OUT` places one output register after it, cleared by the asynchronous active-low reset. With `REG_OUT` set to 0 the output follows the input directly.

Top module: `tanh_ladder`

## Requirements
- R1: `in_i[5]` is the sign (1 = negative). `in_i[4:0]` is the magnitude in units of 1/8, so code 8 means 1.0.
- R2: `out_o[7]` is the sign. `out_o[6]` is the integer bit. `out_o[5:0]` is the fraction in units of 1/64. The magnitude `out_o[6:0]` never exceeds 64 (1.0).
- R3: For a magnitude code m from 0 to 15, the output magnitude equals tanh(m/8)·64 rounded to the nearest integer, so m = 8 gives 49.
- R4: A magnitude code of 16 or more (`in_i[4]` = 1) gives output magnitude 64 (1.000000), whatever `in_i[3:0]` holds.
- R5: A negative input with a non-zero magnitude gives the same magnitude as the positive input, with `out_o[7]` = 1.
- R6: A zero output magnitude always carries sign 0. This includes the input code for negative zero.
- R7: Over the codes 0 to 31, the output magnitude never decreases as the input magnitude rises.
- R8: With `REG_OUT` = 1, `out_o` is 0 while `rst_ni` is low. After reset, `out_o` shows the result for the input sampled at the previous rising edge of `clk_i`, and holds steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_i | input | 6 | Sign plus 5-bit magnitude (3 fractional bits) |
| out_o | output | 8 | Sign, integer bit, 6 fractional bits |

## Verification
The assertions assume that `in_i` is a known value at every rising edge once reset is released. With the default output register, they also assume that the input is captured only at those edges. The bench meets both conditions by changing `in_i` only on falling edges and by holding it for a full cycle before each output sample. The sweep covers all 64 input codes, so no assumption narrows the input range. That includes the negative-zero code and every saturating code.

// File: rtl/tanh_pkg.sv
package tanh_pkg;
  localparam int MAG_W   = 5;              // input magnitude bits
  localparam int IN_FRAC = 3;              // fractional bits of input
  localparam int OUT_FRAC = 6;             // fractional bits of output
  localparam int IDX_W   = MAG_W - 1;      // segment index bits below saturation
  localparam int SEG_N   = 1 << IDX_W;     // segments over [0, 2)
  localparam int LVL_W   = OUT_FRAC + 1;   // integer bit plus fraction
  localparam int IN_W    = MAG_W + 1;
  localparam int OUT_W   = LVL_W + 1;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t SAT_LVL = lvl_t'(1 << OUT_FRAC);

  // tanh(m/8)*64 rounded to nearest, m = 0..15
  localparam lvl_t STEP_LVL [SEG_N] = '{
    7'd0,  7'd8,  7'd16, 7'd23, 7'd30, 7'd35, 7'd41, 7'd45,
    7'd49, 7'd52, 7'd54, 7'd56, 7'd58, 7'd59, 7'd60, 7'd61
  };

  // segments whose level has bit b set: selects product terms for one OR gate
  function automatic logic [SEG_N-1:0] or_mask(input int b);
    logic [SEG_N-1:0] m;
    m = '0;
    for (int s = 0; s < SEG_N; s++) m[s] = STEP_LVL[s][b];
    return m;
  endfunction
endpackage

// File: rtl/tanh_and_plane.sv
module tanh_and_plane
  import tanh_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [SEG_N-1:0] term_o
);
  // one product term per segment, each an AND of true/complement literals
  for (genvar s = 0; s < SEG_N; s++) begin : g_term
    localparam logic [IDX_W-1:0] PAT = IDX_W'(s);
    logic [IDX_W-1:0] lit;
    for (genvar b = 0; b < IDX_W; b++) begin : g_lit
      assign lit[b] = PAT[b] ? idx_i[b] : ~idx_i[b];
    end
    assign term_o[s] = &lit;
  end
endmodule

// File: rtl/tanh_or_plane.sv
module tanh_or_plane
  import tanh_pkg::*;
(
  input  logic [SEG_N-1:0] term_i,
  output lvl_t             lvl_o
);
  for (genvar b = 0; b < LVL_W; b++) begin : g_bit
    localparam logic [SEG_N-1:0] MASK = or_mask(b);
    assign lvl_o[b] = |(term_i & MASK);
  end
endmodule

// File: rtl/tanh_sign_sat.sv
module tanh_sign_sat
  import tanh_pkg::*;
(
  input  logic            sign_i,
  input  logic            over_i,
  input  lvl_t            step_i,
  output logic [OUT_W-1:0] res_o
);
  lvl_t mag;
  always_comb begin
    mag   = over_i ? SAT_LVL : step_i;
    // odd symmetry; zero level keeps positive sign
    res_o = {sign_i & (|mag), mag};
  end
endmodule

// File: rtl/tanh_ladder.sv
module tanh_ladder
  import tanh_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o
);
  logic [SEG_N-1:0] term;
  lvl_t             step;
  logic [OUT_W-1:0] res;

  tanh_and_plane u_and (
    .idx_i (in_i[IDX_W-1:0]),
    .term_o(term)
  );

  tanh_or_plane u_or (
    .term_i(term),
    .lvl_o (step)
  );

  tanh_sign_sat u_sat (
    .sign_i(in_i[IN_W-1]),
    .over_i(|in_i[MAG_W-1:IDX_W]),
    .step_i(step),
    .res_o (res)
  );

  if (REG_OUT) begin : g_reg
    logic [OUT_W-1:0] res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= '0;
      else         res_q <= res;
    end
    assign out_o = res_q;
  end else begin : g_comb
    logic unused;
    assign unused = clk_i ^ rst_ni;
    assign out_o  = res;
  end
endmodule

// File: rtl/tanh_ladder_chk.sv
module tanh_ladder_chk
  import tanh_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IN_W-1:0]  in_i,
  input logic [OUT_W-1:0] out_o
);
  logic            seen_q;
  logic [IN_W-1:0] in_q;
  logic [IN_W-1:0] src;
  logic            ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      in_q   <= '0;
    end else begin
      seen_q <= 1'b1;
      in_q   <= in_i;
    end
  end

  assign src = REG_OUT ? in_q : in_i;
  assign ok  = REG_OUT ? seen_q : 1'b1;

  // R2
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o[OUT_W-2] |-> out_o[OUT_FRAC-1:0] == '0);

  // R6
  no_neg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o[LVL_W-1:0] == '0 |-> !out_o[OUT_W-1]);

  // R4
  sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && src[MAG_W-1]) |-> out_o[LVL_W-1:0] == SAT_LVL);

  // R5
  sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && src[MAG_W-1:0] != '0) |-> out_o[OUT_W-1] == src[IN_W-1]);

  // R3
  zero_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && src[MAG_W-1:0] == '0) |-> out_o == '0);
endmodule

bind tanh_ladder tanh_ladder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .in_i  (in_i),
  .out_o (out_o)
);

// File: tb/tanh_ladder_tb.sv
module tanh_ladder_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] in_i = '0;
  logic [7:0] out_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tanh_ladder u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (in_i),
    .out_o (out_o)
  );

  function automatic logic [7:0] expect_of(input logic [5:0] v);
    int mag;
    if (v[4]) mag = 64;
    else mag = $rtoi($tanh(real'(v[3:0]) / 8.0) * 64.0 + 0.5);
    if (mag == 0) return 8'h00;
    return {v[5], 7'(mag)};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h (in=%02h)", tag, act, exp, in_i);
    end
  endtask

  task automatic apply(input logic [5:0] v);
    @(negedge clk_i);
    in_i = v;
    @(negedge clk_i);
  endtask

  initial begin
    logic [7:0] prev;
    string tag;
    in_i = 6'h2A;
    #12;
    // R8 reset state
    check("R8", out_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R2: 1.0 input gives 49/64
    apply(6'b001000);
    check("R1", out_o, 8'h31);
    check("R2", out_o[6:0], 7'd49);

    // exhaustive sweep
    for (int c = 0; c < 64; c++) begin
      apply(6'(c));
      if (c[4]) tag = "R4";
      else if (c[3:0] == 0) tag = "R6";
      else if (c[5]) tag = "R5";
      else tag = "R3";
      check(tag, out_o, expect_of(6'(c)));
    end

    // R7 staircase monotone, positive side
    apply(6'd0);
    prev = out_o;
    for (int m = 1; m < 32; m++) begin
      apply(6'(m));
      check("R7", 8'(out_o >= prev), 8'h01);
      prev = out_o;
    end

    // R5 mirrored pair
    apply(6'h25);
    check("R5", out_o, {1'b1, 7'd35});

    // R8 output holds between edges after input change
    apply(6'h0C);
    in_i = 6'h1F;
    #2;
    check("R8", out_o, expect_of(6'h0C));
    @(posedge clk_i);
    #2;
    check("R8", out_o, expect_of(6'h1F));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule